// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block decides, for every generated clock output of a clock synthesizer, whether it toggles, is held low, or is left undriven. It merges a per-output enable vector from the configuration registers, a global tristate bit, and an asynchronous active-low power-down pin. The raw divider outputs come in as `srcClk`. They are levels in the `clk` domain. Each one leaves as `clkOut` through a gate that can only open or close while its source is low, so no output ever shows a shortened pulse.

When power-down is requested, the sequencer first lets every output reach its next low level and holds it there. Only when all gates report closed does it turn off the oscillator enable and the PLL enable. On release, it restarts the oscillator, then the PLL one cycle later. The outputs stay held low until the PLL reports lock or a settling timeout expires. After that, the outputs resume according to their enables. The analog parts are reduced to `oscEn`, `pllEn` and the synchronous `pllLock` input.

Top module: `pdseq_top`

## Requirements
- R1: `pwrDnN` passes through a SYNC_STAGES-deep synchronizer (default 2). In the first clock after `pwrDnN` changes, `oscEn` and `clkOut` are unaffected by the change.
- R2: An enable bit of 1 makes its `clkOut` bit equal its `srcClk` bit while running. A bit of 0 holds the output low. Out of reset all gates are closed (`clkOut` = 0) and `oscEn` = `pllEn` = 1.
- R3: A gate changes state only while its source is low. `clkOut` rises only with a rising source and falls only with a falling source, so every high pulse is a whole source pulse.
- R4: `triAll` = 1 makes `outDrive` all zeros in every state, power-down included. `triAll` = 0 drives every output.
- R5: After power-down is requested, each output stops at its source's next low level. It then stays low whatever the enable vector does, until the outputs are released.
- R6: `oscEn` and `pllEn` fall only after every output has stopped. `clkOut` is all zeros whenever `oscEn` is 0. `pllEn` is never 1 while `oscEn` is 0.
- R7: On release, `oscEn` rises with all outputs still low and `pllEn` follows. The outputs stay held low until `pllLock` is seen, then resume per their enables.
- R8: Without `pllLock`, the outputs resume after WAKE_CYCLES clocks (default 1024) in the wake state.
- R9: A release that arrives while outputs are still stopping does not abort the sequence. The oscillator is still switched off for at least one cycle before waking.
- R10: A new power-down request during the wake wait returns to the off state, with the outputs held low and the oscillator disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Asynchronous active-low power-down request |
| triAll | input | 1 | 1 = release every output to high impedance |
| pllLock | input | 1 | PLL lock indication, synchronous to `clk` |
| outEnCfg | input | NOUT | Per-output enable, 1 = run, 0 = hold low |
| srcClk | input | NOUT | Ungated divider outputs |
| clkOut | output | NOUT | Gated clock outputs |
| outDrive | output | NOUT | Output driver enable, 0 = high impedance |
| oscEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL enable |

## Verification
The hardest situation to reach is a release of power-down that arrives while the sequencer is still waiting for outputs to stop. Normally the sources fall within a few cycles, so this window is very short. The bench therefore forces every source high, which parks the sequencer in the stopping state. It pulses the power-down pin and releases it while the outputs are still high, then lets the sources run again. It checks that the outputs kept their full pulses, that the oscillator still dropped, and that the outputs later returned.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_STOPPING = 2'd1,
    ST_OFF      = 2'd2,
    ST_WAKE     = 2'd3
  } pdState_e;

  // strobes from the sequencer to the gating datapath
  typedef struct packed {
    logic holdLow;   // close every gate at its next low level
    logic tristate;  // release all drivers
  } gateCtl_t;

endpackage

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwrDnN,
  input  logic     triAll,
  input  logic     pllLock,
  input  logic     allStopped,
  output gateCtl_t ctl,
  output logic     oscEn,
  output logic     pllEn
);

  localparam int CW = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pdReq;
  pdState_e               state, nextState;
  logic [CW-1:0]          wakeCnt;

  // request synchronizer, idle level is "not powered down"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pwrDnN};
  end
  assign pdReq = ~syncQ[SYNC_STAGES-1];

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:      if (pdReq) nextState = ST_STOPPING;
      // a release here lets the stop sequence finish first
      ST_STOPPING: if (allStopped) nextState = ST_OFF;
      ST_OFF:      if (!pdReq) nextState = ST_WAKE;
      ST_WAKE: begin
        if (pdReq)                              nextState = ST_OFF;
        else if (pllLock || wakeCnt == WAKE_LAST) nextState = ST_RUN;
      end
      default:     nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wakeCnt <= '0;
      oscEn   <= 1'b1;
      pllEn   <= 1'b1;
    end else begin
      state   <= nextState;
      wakeCnt <= (state == ST_WAKE && nextState == ST_WAKE) ? wakeCnt + CW'(1) : '0;
      oscEn   <= (nextState != ST_OFF);
      // PLL starts one cycle behind the oscillator, stops together with it
      pllEn   <= (nextState != ST_OFF) && oscEn;
    end
  end

  always_comb begin
    ctl.holdLow  = (state != ST_RUN);
    ctl.tristate = triAll;
  end

endmodule

// File: rtl/pdseq_gate.sv
module pdseq_gate
  import pdseq_pkg::*;
#(
  parameter int NOUT = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NOUT-1:0] srcClk,
  input  logic [NOUT-1:0] outEnCfg,
  input  gateCtl_t        ctl,
  output logic [NOUT-1:0] clkOut,
  output logic [NOUT-1:0] outDrive,
  output logic            allStopped
);

  logic [NOUT-1:0] gateQ;

  for (genvar i = 0; i < NOUT; i++) begin : g_lane
    logic gateBit;
    // the gate may only move while its source sits low
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           gateBit <= 1'b0;
      else if (!srcClk[i]) gateBit <= outEnCfg[i] & ~ctl.holdLow;
    end
    assign gateQ[i] = gateBit;
  end

  assign clkOut     = srcClk & gateQ;
  assign outDrive   = {NOUT{~ctl.tristate}};
  assign allStopped = ~|gateQ;

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int NOUT        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pwrDnN,
  input  logic            triAll,
  input  logic            pllLock,
  input  logic [NOUT-1:0] outEnCfg,
  input  logic [NOUT-1:0] srcClk,
  output logic [NOUT-1:0] clkOut,
  output logic [NOUT-1:0] outDrive,
  output logic            oscEn,
  output logic            pllEn
);

  gateCtl_t ctl;
  logic     allStopped;

  pdseq_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDnN    (pwrDnN),
    .triAll    (triAll),
    .pllLock   (pllLock),
    .allStopped(allStopped),
    .ctl       (ctl),
    .oscEn     (oscEn),
    .pllEn     (pllEn)
  );

  pdseq_gate #(
    .NOUT(NOUT)
  ) u_gate (
    .clk       (clk),
    .rstN      (rstN),
    .srcClk    (srcClk),
    .outEnCfg  (outEnCfg),
    .ctl       (ctl),
    .clkOut    (clkOut),
    .outDrive  (outDrive),
    .allStopped(allStopped)
  );

endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
  parameter int NOUT = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [NOUT-1:0] srcClk,
  input logic [NOUT-1:0] clkOut,
  input logic            oscEn,
  input logic            pllEn
);

  p_rise_at_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((clkOut & ~$past(clkOut)) & $past(srcClk)) == '0);

  p_fall_at_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~clkOut & $past(clkOut)) & srcClk) == '0);

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> clkOut == '0);

  p_stop_before_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscEn) |-> $past(clkOut) == '0);

  p_pll_needs_osc_r6: assert property (@(posedge clk) disable iff (!rstN)
    pllEn |-> oscEn);

  p_wake_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> clkOut == '0);

endmodule

bind pdseq_top pdseq_checker #(.NOUT(NOUT)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .srcClk(srcClk),
  .clkOut(clkOut),
  .oscEn (oscEn),
  .pllEn (pllEn)
);

// File: tb/pdseq_top_tb.sv
`timescale 1ns/1ps
module pdseq_top_tb;

  localparam int NOUT = 8;
  localparam int WAKE = 1024;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            pwrDnN = 1'b1;
  logic            triAll = 1'b0;
  logic            pllLock = 1'b0;
  logic [NOUT-1:0] outEnCfg = '1;
  logic [NOUT-1:0] srcClk = '0;
  logic [NOUT-1:0] clkOut, outDrive;
  logic            oscEn, pllEn;

  int checks = 0;
  int failures = 0;
  bit holdHigh = 1'b0;
  bit sawOff = 1'b0;
  int runtViol = 0;
  int offViol = 0;

  always #2 clk = ~clk;

  pdseq_top #(.NOUT(NOUT), .SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .triAll(triAll), .pllLock(pllLock),
    .outEnCfg(outEnCfg), .srcClk(srcClk), .clkOut(clkOut), .outDrive(outDrive),
    .oscEn(oscEn), .pllEn(pllEn)
  );

  // source i toggles every i+1 clocks
  int phase [NOUT];
  initial for (int i = 0; i < NOUT; i++) phase[i] = 0;
  always @(negedge clk) begin
    if (holdHigh) srcClk <= '1;
    else begin
      for (int i = 0; i < NOUT; i++) begin
        if (phase[i] >= i) begin
          phase[i] = 0;
          srcClk[i] <= ~srcClk[i];
        end else phase[i] = phase[i] + 1;
      end
    end
  end

  // independent monitor for whole pulses and quiet-while-off
  logic [NOUT-1:0] prevOut = '0, prevSrc = '0;
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      for (int i = 0; i < NOUT; i++) begin
        if (clkOut[i] && !prevOut[i] && prevSrc[i]) runtViol++;
        if (!clkOut[i] && prevOut[i] && srcClk[i]) runtViol++;
      end
      if (!oscEn && clkOut != '0) offViol++;
      if (!oscEn) sawOff = 1'b1;
    end
    prevOut = clkOut;
    prevSrc = srcClk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic expect_follow(input string req, input logic [NOUT-1:0] mask, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (clkOut !== (srcClk & mask)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic expect_low(input string req, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (clkOut !== '0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    tick(3);
    check(clkOut == '0 && outDrive == '1, "R2 reset outputs", {clkOut, outDrive}, {8'h00, 8'hff});
    check(oscEn && pllEn, "R2 reset enables", {oscEn, pllEn}, 2'b11);
    drive_edge(); rstN = 1'b1;
  endtask

  task automatic t_run_masks();
    drive_edge(); outEnCfg = '1;
    tick(20);
    expect_follow("R2 all enabled", 8'hff, 40);
    drive_edge(); outEnCfg = 8'ha5;
    tick(20);
    expect_follow("R2 mask a5", 8'ha5, 40);
    drive_edge(); outEnCfg = 8'h00;
    tick(20);
    expect_follow("R2 all disabled", 8'h00, 20);
  endtask

  task automatic t_enable_churn();
    for (int k = 0; k < 120; k++) begin
      drive_edge(); outEnCfg = 8'(k * 37 + 11);
    end
    tick(2);
    check(runtViol == 0, "R3 no partial pulse under enable churn", runtViol, 0);
  endtask

  task automatic t_tristate();
    drive_edge(); triAll = 1'b1;
    tick();
    check(outDrive == '0, "R4 tristate on", outDrive, 0);
    drive_edge(); triAll = 1'b0;
    tick();
    check(outDrive == '1, "R4 tristate off", outDrive, 8'hff);
  endtask

  task automatic t_powerdown();
    drive_edge(); outEnCfg = '1;
    tick(20);
    drive_edge(); pwrDnN = 1'b0;
    tick();
    check(oscEn && clkOut == srcClk, "R1 first cycle unaffected", {oscEn, clkOut}, {1'b1, srcClk});
    tick(40);
    check(!oscEn && !pllEn, "R6 oscillator and PLL off", {oscEn, pllEn}, 2'b00);
    check(clkOut == '0, "R5 outputs stopped low", clkOut, 0);
    drive_edge(); outEnCfg = 8'h3c;
    expect_low("R5 enables ignored while down", 16);
    drive_edge(); triAll = 1'b1;
    tick();
    check(outDrive == '0, "R4 tristate while down", outDrive, 0);
    drive_edge(); triAll = 1'b0; outEnCfg = '1;
    check(offViol == 0, "R6 outputs low whenever oscillator off", offViol, 0);
  endtask

  task automatic t_wake_lock();
    drive_edge(); pllLock = 1'b0; pwrDnN = 1'b1;
    tick();
    check(!oscEn, "R1 release not seen in first cycle", oscEn, 0);
    tick(6);
    check(oscEn && pllEn && clkOut == '0, "R7 enables up, outputs held", {oscEn, pllEn, clkOut}, {2'b11, 8'h00});
    expect_low("R7 held until lock", 20);
    drive_edge(); pllLock = 1'b1;
    tick(30);
    expect_follow("R7 resume after lock", 8'hff, 40);
    drive_edge(); pllLock = 1'b0;
  endtask

  task automatic t_wake_timeout();
    drive_edge(); pwrDnN = 1'b0;
    tick(40);
    check(!oscEn, "R8 down before timeout test", oscEn, 0);
    drive_edge(); pwrDnN = 1'b1;
    tick(WAKE - 10);
    check(oscEn && clkOut == '0, "R8 still waiting before timeout", {oscEn, clkOut}, {1'b1, 8'h00});
    tick(50);
    expect_follow("R8 resume after timeout", 8'hff, 40);
  endtask

  task automatic t_release_in_stop();
    drive_edge(); holdHigh = 1'b1;
    tick(4);
    sawOff = 1'b0;
    drive_edge(); pwrDnN = 1'b0;
    tick(4);
    drive_edge(); pwrDnN = 1'b1;
    tick(20);
    check(oscEn && clkOut == '1, "R9 stopping waits on high sources", {oscEn, clkOut}, {1'b1, 8'hff});
    drive_edge(); holdHigh = 1'b0;
    tick(40);
    check(sawOff, "R9 oscillator still switched off", sawOff, 1);
    drive_edge(); pllLock = 1'b1;
    tick(30);
    expect_follow("R9 resume after completed sequence", 8'hff, 40);
    drive_edge(); pllLock = 1'b0;
  endtask

  task automatic t_reassert_in_wake();
    drive_edge(); pwrDnN = 1'b0;
    tick(40);
    drive_edge(); pwrDnN = 1'b1;
    tick(20);
    check(oscEn && clkOut == '0, "R10 in wake wait", {oscEn, clkOut}, {1'b1, 8'h00});
    drive_edge(); pwrDnN = 1'b0;
    tick(10);
    check(!oscEn && !pllEn && clkOut == '0, "R10 back to off", {oscEn, pllEn, clkOut}, 0);
    drive_edge(); pwrDnN = 1'b1; pllLock = 1'b1;
    tick(30);
    expect_follow("R10 recovers after second release", 8'hff, 40);
    drive_edge(); pllLock = 1'b0;
  endtask

  initial begin
    t_reset();
    t_run_masks();
    t_enable_churn();
    t_tristate();
    t_powerdown();
    t_wake_lock();
    t_wake_timeout();
    t_release_in_stop();
    t_reassert_in_wake();
    check(runtViol == 0, "R3 whole pulses over whole run", runtViol, 0);
    check(offViol == 0, "R6 quiet while off over whole run", offViol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule